// File: doc/BRIEF.md
# Up/Down Wiper Position Controller

This block is the digital control section of a 128-position digitally controlled potentiometer. A host drives three slow, asynchronous, active-low-style control lines: a select line (`csN`, active low), a step strobe (`incN`, acting on its falling edge) and a direction line (`upDn`). The block brings them into the system clock domain through synchronizers. It moves a 7-bit wiper code one position per step strobe, stopping at either end. It presents the code both in binary and as a one-hot tap-select vector that drives the analog switch network.

When the host releases the select line, the level of the step strobe at that moment decides the next action. With the strobe high, the current code is committed to a modelled non-volatile register, and a self-timed store interval follows. With the strobe low, the block returns to standby without storing. A reset models power-up: the wiper code is reloaded from the non-volatile register, so the wiper comes back at the last committed position. The register holds a parameterised initial code until the first commit.

Top module: `updown_wiper`

## Requirements
- R1: During and after reset the wiper code equals the value held in the non-volatile register (`NV_INIT` before any commit). After reset `standby` is 1 and `storeBusy` is 0.
- R2: While the synchronized select line is high, falling edges on `incN` and levels on `upDn` leave the wiper code unchanged.
- R3: While selected, each falling edge of `incN` moves the code by one: up (+1) when `upDn` is 1 and down (-1) when `upDn` is 0. The change appears three clock edges after the input edge.
- R4: The code saturates and never wraps. An up step at 0x7F leaves 0x7F, and a down step at 0x00 leaves 0x00.
- R5: A rising edge of the select line while `incN` is high commits the code to the non-volatile register. `storeBusy` is then 1 for exactly `STORE_CYCLES` consecutive cycles, after which `standby` is 1.
- R6: A rising edge of the select line while `incN` is low performs no commit and no step, even when `incN` falls in the same sampled cycle. `storeBusy` stays 0 and the wiper keeps its position until the next step or reset.
- R7: While `storeBusy` is 1, changes on `csN` and `incN` are ignored. The code stays constant, and no further commit is started by them.
- R8: `tapSel` is one-hot, with bit number equal to the wiper code.
- R9: A change of `upDn` while the block stays selected is legal and sets the direction of the next step.
- R10: `standby` is 1 exactly when the block is neither selected nor storing. It drops to 0 once a low select line has been sampled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset, models power-up and triggers recall |
| csN | input | 1 | Select, active low, asynchronous |
| incN | input | 1 | Step strobe, acts on its falling edge, asynchronous |
| upDn | input | 1 | Step direction, 1 = up, 0 = down, asynchronous |
| tapSel | output | 128 | One-hot tap select, bit index equals wiper code |
| wiperCode | output | 7 | Binary wiper code |
| storeBusy | output | 1 | High during the self-timed store interval |
| standby | output | 1 | High while neither selected nor storing |

## Verification
The two functions that can land in one sampled cycle are the deselect decision and a step: a falling edge of `incN` can be synchronized in the same cycle as the rise of `csN`. The bench provokes this by driving both lines on the same clock. It then judges that the code did not move, that `storeBusy` never rose, and that a later reset recalls the earlier stored code rather than the current one. A second overlap is saturation with a step at the end positions, covered by full up and down sweeps past both ends. A third is store timing with host activity: select and step-strobe toggles are injected in the middle of the store interval, and the bench checks that they are ignored.

// File: rtl/wpot_pkg.sv
package wpot_pkg;

  // Strobes handed from the control FSM to the wiper datapath.
  typedef struct packed {
    logic stepUp;
    logic stepDown;
    logic commit;
  } wiperCmd_t;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ACTIVE = 2'd1,
    ST_STORE  = 2'd2
  } ctrlState_t;

endpackage

// File: rtl/wpot_sync.sv
module wpot_sync #(
  parameter int STAGES  = 2,
  parameter bit RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (!rst_n) chain <= {STAGES{RST_VAL}};
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];

endmodule

// File: rtl/wpot_ctrl.sv
module wpot_ctrl
  import wpot_pkg::*;
#(
  parameter int STORE_CYCLES = 5_000_000,
  parameter int SYNC_STAGES  = 2
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      csN,
  input  logic      incN,
  input  logic      upDn,
  output wiperCmd_t cmd,
  output logic      storeBusy,
  output logic      standby
);

  localparam int CNT_W = $clog2(STORE_CYCLES) + 1;

  logic csS, incS, upS;
  logic incPrev;
  logic incFall;
  ctrlState_t state;
  logic [CNT_W-1:0] holdCnt;

  // Each asynchronous input gets its own synchronizer chain.
  wpot_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_csSync  (.clk(clk), .rst_n(rst_n), .d(csN),  .q(csS));
  wpot_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_incSync (.clk(clk), .rst_n(rst_n), .d(incN), .q(incS));
  wpot_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_upSync  (.clk(clk), .rst_n(rst_n), .d(upDn), .q(upS));

  assign incFall = incPrev & ~incS;

  always_comb begin
    cmd          = '0;
    cmd.stepUp   = (state == ST_ACTIVE) & ~csS & incFall &  upS;
    cmd.stepDown = (state == ST_ACTIVE) & ~csS & incFall & ~upS;
    cmd.commit   = (state == ST_ACTIVE) &  csS & incS;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      incPrev <= 1'b1;
      holdCnt <= '0;
    end else begin
      incPrev <= incS;
      case (state)
        ST_IDLE: begin
          if (!csS) state <= ST_ACTIVE;
        end
        ST_ACTIVE: begin
          // Deselect: strobe level picks store or plain return to standby.
          if (csS) begin
            if (incS) begin
              state   <= ST_STORE;
              holdCnt <= CNT_W'(STORE_CYCLES - 1);
            end else begin
              state <= ST_IDLE;
            end
          end
        end
        ST_STORE: begin
          // Self-timed interval: host lines are not looked at.
          if (holdCnt == '0) state <= ST_IDLE;
          else               holdCnt <= holdCnt - 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign storeBusy = (state == ST_STORE);
  assign standby   = (state == ST_IDLE);

  // R5: a commit strobe is followed by the busy interval.
  a_r5_busy_after_commit: assert property (@(posedge clk) disable iff (!rst_n)
    cmd.commit |=> storeBusy);

  // R5: the busy interval ends in standby.
  a_r5_end_in_standby: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(storeBusy) |-> standby);

  // R2: no step strobe while the sampled select is inactive.
  a_r2_no_step_deselected: assert property (@(posedge clk) disable iff (!rst_n)
    standby |-> !(cmd.stepUp || cmd.stepDown));

  // R10: standby is left only towards the selected state.
  a_r10_leave_standby: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(standby) |-> !storeBusy);

endmodule

// File: rtl/wpot_datapath.sv
module wpot_datapath
  import wpot_pkg::*;
#(
  parameter int CODE_W  = 7,
  parameter int NV_INIT = 64,
  localparam int TAPS   = 1 << CODE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  wiperCmd_t         cmd,
  input  logic              storeBusy,
  output logic [CODE_W-1:0] wiperCode,
  output logic [TAPS-1:0]   tapSel
);

  localparam logic [CODE_W-1:0] MAX_CODE = CODE_W'(TAPS - 1);

  // Non-volatile register model: keeps its content across rst_n.
  logic [CODE_W-1:0] nvCode = CODE_W'(NV_INIT);

  always_ff @(posedge clk) begin
    if (cmd.commit) nvCode <= wiperCode;
  end

  // Wiper counter, recalled from the NV model at power-up reset.
  always_ff @(posedge clk) begin
    if (!rst_n)
      wiperCode <= nvCode;
    else if (cmd.stepUp && (wiperCode != MAX_CODE))
      wiperCode <= wiperCode + 1'b1;
    else if (cmd.stepDown && (wiperCode != '0))
      wiperCode <= wiperCode - 1'b1;
  end

  for (genvar g = 0; g < TAPS; g++) begin : g_tap
    assign tapSel[g] = (wiperCode == CODE_W'(g));
  end

  // R3: an up step below the top raises the code by one.
  a_r3_step_up: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd.stepUp && wiperCode != MAX_CODE) |=> wiperCode == CODE_W'($past(wiperCode) + 1'b1));

  // R3: a down step above zero lowers the code by one.
  a_r3_step_down: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd.stepDown && wiperCode != '0) |=> wiperCode == CODE_W'($past(wiperCode) - 1'b1));

  // R4: saturation at both ends.
  a_r4_no_wrap_top: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd.stepUp && wiperCode == MAX_CODE) |=> wiperCode == MAX_CODE);
  a_r4_no_wrap_bottom: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd.stepDown && wiperCode == '0) |=> wiperCode == '0);

  // R5: the NV model holds the code present at the commit.
  a_r5_commit_value: assert property (@(posedge clk) disable iff (!rst_n)
    cmd.commit |=> nvCode == $past(wiperCode));

  // R7: code and NV content frozen inside the store interval.
  a_r7_frozen_in_store: assert property (@(posedge clk) disable iff (!rst_n)
    (storeBusy && $past(storeBusy)) |-> ($stable(wiperCode) && $stable(nvCode)));

  // R8: exactly one tap selected.
  a_r8_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(tapSel) == 1);

endmodule

// File: rtl/updown_wiper.sv
module updown_wiper
  import wpot_pkg::*;
#(
  parameter int CODE_W       = 7,
  parameter int STORE_CYCLES = 5_000_000,
  parameter int SYNC_STAGES  = 2,
  parameter int NV_INIT      = 64,
  localparam int TAPS        = 1 << CODE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              csN,
  input  logic              incN,
  input  logic              upDn,
  output logic [TAPS-1:0]   tapSel,
  output logic [CODE_W-1:0] wiperCode,
  output logic              storeBusy,
  output logic              standby
);

  wiperCmd_t cmd;

  wpot_ctrl #(
    .STORE_CYCLES(STORE_CYCLES),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .csN      (csN),
    .incN     (incN),
    .upDn     (upDn),
    .cmd      (cmd),
    .storeBusy(storeBusy),
    .standby  (standby)
  );

  wpot_datapath #(
    .CODE_W (CODE_W),
    .NV_INIT(NV_INIT)
  ) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd      (cmd),
    .storeBusy(storeBusy),
    .wiperCode(wiperCode),
    .tapSel   (tapSel)
  );

endmodule

// File: tb/sim_updown_wiper.sv
module sim_updown_wiper;

  localparam int STORE = 40;
  localparam int NVI   = 64;
  localparam int TAPS  = 128;

  logic clk = 1'b0;
  logic rst_n, csN, incN, upDn;
  logic [TAPS-1:0] tapSel;
  logic [6:0] wiperCode;
  logic storeBusy, standby;

  int checks = 0;
  int fails  = 0;
  int expCode;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  updown_wiper #(
    .CODE_W(7), .STORE_CYCLES(STORE), .SYNC_STAGES(2), .NV_INIT(NVI)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .csN(csN), .incN(incN), .upDn(upDn),
    .tapSel(tapSel), .wiperCode(wiperCode), .storeBusy(storeBusy), .standby(standby)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chkCode(input string req, input int exp);
    chk(int'(wiperCode) == exp, req, int'(wiperCode), exp);
    checks++;
    if (tapSel !== (TAPS'(1) << exp)) begin
      fails++;
      $display("FAIL R8 tapSel actual=%h expected bit %0d", tapSel, exp);
    end
  endtask

  task automatic pulseInc();
    incN = 1'b0; tick(6);
    incN = 1'b1; tick(6);
  endtask

  task automatic doReset();
    rst_n = 1'b0; tick(4);
    rst_n = 1'b1; tick(6);
  endtask

  // Store with host activity injected mid-interval (R5, R7).
  task automatic storeWithNoise(input int holdCode);
    int busyCnt = 0;
    csN = 1'b1;
    for (int i = 0; i < STORE + 30; i++) begin
      if (i == 5)  begin csN = 1'b0; incN = 1'b0; end
      if (i == 10) incN = 1'b1;
      if (i == 15) csN = 1'b1;
      tick(1);
      if (storeBusy) busyCnt++;
    end
    chk(busyCnt == STORE, "R5 busy length", busyCnt, STORE);
    chk(standby == 1'b1, "R5 standby after store", int'(standby), 1);
    chkCode("R7 code unchanged by noise", holdCode);
    tick(10);
    chk(storeBusy == 1'b0, "R7 no second store", int'(storeBusy), 0);
  endtask

  initial begin
    rst_n = 1'b0; csN = 1'b1; incN = 1'b1; upDn = 1'b0;
    tick(5);
    rst_n = 1'b1;
    tick(6);
    chkCode("R1 reset recall of initial value", NVI);
    chk(standby == 1'b1, "R1 standby after reset", int'(standby), 1);
    chk(storeBusy == 1'b0, "R1 busy after reset", int'(storeBusy), 0);
    expCode = NVI;

    // R2: strobes ignored while deselected.
    upDn = 1'b1;
    for (int i = 0; i < 3; i++) pulseInc();
    chkCode("R2 deselected steps ignored", expCode);
    chk(standby == 1'b1, "R10 standby while deselected", int'(standby), 1);

    // Select.
    csN = 1'b0; tick(6);
    chk(standby == 1'b0, "R10 standby cleared on select", int'(standby), 0);

    // R3/R4 up sweep past the top.
    for (int i = 0; i < 100; i++) begin
      pulseInc();
      expCode = (expCode == 127) ? 127 : expCode + 1;
      chkCode("R3 R4 up sweep", expCode);
    end

    // R9 direction change while selected, then down sweep past zero.
    upDn = 1'b0; tick(6);
    for (int i = 0; i < 140; i++) begin
      pulseInc();
      expCode = (expCode == 0) ? 0 : expCode - 1;
      chkCode("R9 R3 R4 down sweep", expCode);
    end

    // R9 back to up.
    upDn = 1'b1; tick(6);
    for (int i = 0; i < 5; i++) pulseInc();
    expCode = 5;
    chkCode("R9 up after direction change", expCode);

    // R5 store with R7 noise.
    storeWithNoise(5);

    // R6: select, move to 8, deselect with incN falling in the same cycle.
    csN = 1'b0; tick(6);
    for (int i = 0; i < 3; i++) pulseInc();
    chkCode("R3 step to 8", 8);
    csN = 1'b1; incN = 1'b0;
    for (int i = 0; i < 10; i++) begin
      tick(1);
      chk(storeBusy == 1'b0, "R6 no store on low strobe", int'(storeBusy), 0);
    end
    chkCode("R6 no step with deselect collision", 8);
    chk(standby == 1'b1, "R6 standby after plain deselect", int'(standby), 1);
    incN = 1'b1; tick(6);
    chkCode("R6 position kept", 8);

    // R1/R6: reset recalls 5, not 8.
    doReset();
    chkCode("R1 R6 recall of stored value", 5);

    // R5: plain store of 6, then recall.
    csN = 1'b0; tick(6);
    pulseInc();
    csN = 1'b1; tick(6);
    chk(storeBusy == 1'b1, "R5 busy after store start", int'(storeBusy), 1);
    tick(STORE + 10);
    chk(storeBusy == 1'b0, "R5 busy cleared", int'(storeBusy), 0);
    doReset();
    chkCode("R5 R1 recall of newly stored value", 6);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    finished = 1'b1;
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule